// File: doc/BRIEF.md
# Reference Clock Switch Sequencer

This block moves a transceiver channel's clock-recovery reference clock to a chosen logical source without software issuing the individual register accesses. A caller presents a logical clock index together with a one-cycle request. The block first wins the reconfiguration bus through a request/grant handshake. It then reads the per-index lookup register that holds the physical mapping for that index and keeps its low byte. Next it reads the clock-select multiplexer register and writes it back with only its low byte replaced by the saved mapping.

The preparatory reconfiguration steps are represented only by the grant. The post-switch steps are triggered by the one-cycle done pulse. An index beyond the configured number of reference clocks is refused at once: the block raises its error flag and touches neither the arbiter nor the bus.

Top module: `refsw_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `sw_busy`, `sw_done`, `sw_err`, `arb_req`, `bus_rd` and `bus_wr` are all low.
- R2: A request with index below `NUM_CLK`, seen while idle, raises `sw_busy` and `arb_req` on the next cycle. No bus access starts until `arb_gnt` is seen high, and every access occurs while `arb_req` is high.
- R3: The first access is a read of the lookup register at address 0x16A plus the index (0x16A to 0x16E).
- R4: The second access is a read of the multiplexer register at address 0x141.
- R5: The third and last access is a write to address 0x141. Its data is bits [31:8] of the value read from 0x141 and, in bits [7:0], bits [7:0] of the value read from the lookup register. Upper lookup bits are discarded.
- R6: While `bus_wait` is high, an active read or write keeps its command, address and write data unchanged. Read data is taken on the cycle where `bus_wait` is low.
- R7: `arb_req` stays high from acceptance until the write completes and falls on the cycle after the write is accepted.
- R8: `sw_done` is high for exactly one cycle, on the cycle after the write is accepted. `sw_busy` is high from the cycle after acceptance through the done cycle, and low after it.
- R9: A request presented while `sw_busy` is high is ignored. The running switch keeps its original index, and no second switch follows.
- R10: A request with index at or above `NUM_CLK` sets `sw_err` on the next cycle without raising `sw_busy` or `arb_req` and without any bus access. `sw_err` stays set until the next accepted request clears it.
- R11: `bus_rd` and `bus_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Switch request, sampled while idle |
| sw_idx | input | IDX_W (3) | Logical reference clock index |
| sw_busy | output | 1 | Switch in progress |
| sw_done | output | 1 | One-cycle completion pulse |
| sw_err | output | 1 | Last request was refused |
| arb_req | output | 1 | Reconfiguration bus request |
| arb_gnt | input | 1 | Reconfiguration bus grant |
| bus_addr | output | ADDR_W (10) | Register address |
| bus_rd | output | 1 | Read command |
| bus_wr | output | 1 | Write command |
| bus_wdata | output | DATA_W (32) | Write data |
| bus_rdata | input | DATA_W (32) | Read data |
| bus_wait | input | 1 | Wait-request, stalls the current access |

## Verification
The assertions assume that the arbiter keeps `arb_gnt` high for as long as `arb_req` stays high once it has granted, and that `bus_wait` eventually falls. The bench's register-file model grants after a random delay and keeps the grant until the request drops. It holds wait-request for a bounded random number of cycles, with one directed run that uses long stalls. Requests are driven only on falling edges. Disturbing requests are placed only while the block is busy and well before completion, so they never overlap a return to idle.

// File: rtl/refsw_pkg.sv
// Package: shared types for the reference clock switch sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package refsw_pkg;

    // Sequencer phases, in execution order.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_RD_LKUP,
        ST_RD_SEL,
        ST_WR_SEL,
        ST_FIN
    } seq_state_e;

    // Command presented to the bus master.
    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_RD,
        CMD_WR
    } bus_cmd_e;

endpackage

// File: rtl/refsw_req_check.sv
// Module: refsw_req_check
// Decides whether a requested logical index is within the configured
// number of reference clocks and forms its lookup register address.
// Assumes: NUM_CLK is between 2 and 2**IDX_W; purely combinational.
module refsw_req_check #(
    parameter int                 NUM_CLK   = 5,
    parameter int                 IDX_W     = 3,
    parameter int                 ADDR_W    = 10,
    parameter logic [ADDR_W-1:0]  LKUP_BASE = 10'h16A
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              idx_ok,
    output logic [ADDR_W-1:0] lkup_addr
);
    localparam int IDX_SPAN = 1 << IDX_W;

    logic [IDX_SPAN-1:0] ok_vec;

    // One validity bit per encodable index, fixed by NUM_CLK.
    for (genvar gi = 0; gi < IDX_SPAN; gi++) begin : g_ok
        assign ok_vec[gi] = (gi < NUM_CLK);
    end

    // Select the validity bit for the requested index.
    always_comb idx_ok = ok_vec[idx];

    // Lookup registers sit at consecutive addresses from the base.
    always_comb lkup_addr = LKUP_BASE + ADDR_W'(idx);

endmodule

// File: rtl/refsw_fsm.sv
// Module: refsw_fsm
// Control sequencer: accepts or refuses a request, waits for the bus
// grant, steps through lookup read, select read and select write, then
// emits the done pulse. Holds the sticky error flag.
// Assumes: xfer_ack is high only while a command is presented.
module refsw_fsm
    import refsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       idx_ok,
    input  logic       arb_gnt,
    input  logic       xfer_ack,
    output logic       accept,
    output bus_cmd_e   cmd,
    output logic       use_sel_addr,
    output logic       cap_lkup,
    output logic       cap_sel,
    output logic       arb_req,
    output logic       busy,
    output logic       done,
    output logic       err
);
    seq_state_e state_q;

    // Acceptance only from idle with an in-range index.
    always_comb accept = (state_q == ST_IDLE) && req && idx_ok;

    // State and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req && idx_ok) begin
                        state_q <= ST_ARB;
                        err     <= 1'b0;
                    end else if (req) begin
                        err     <= 1'b1;
                    end
                end
                ST_ARB:     if (arb_gnt)  state_q <= ST_RD_LKUP;
                ST_RD_LKUP: if (xfer_ack) state_q <= ST_RD_SEL;
                ST_RD_SEL:  if (xfer_ack) state_q <= ST_WR_SEL;
                ST_WR_SEL:  if (xfer_ack) state_q <= ST_FIN;
                ST_FIN:                   state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus command and address choice per phase.
    always_comb begin
        unique case (state_q)
            ST_RD_LKUP, ST_RD_SEL: cmd = CMD_RD;
            ST_WR_SEL:             cmd = CMD_WR;
            default:               cmd = CMD_NONE;
        endcase
        use_sel_addr = (state_q != ST_RD_LKUP);
    end

    // Capture strobes for the datapath.
    always_comb begin
        cap_lkup = (state_q == ST_RD_LKUP) && xfer_ack;
        cap_sel  = (state_q == ST_RD_SEL)  && xfer_ack;
    end

    // Handshake and status outputs.
    always_comb begin
        arb_req = (state_q == ST_ARB)     || (state_q == ST_RD_LKUP) ||
                  (state_q == ST_RD_SEL)  || (state_q == ST_WR_SEL);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FIN);
    end

endmodule

// File: rtl/refsw_datapath.sv
// Module: refsw_datapath
// Holds the latched lookup address, the saved mapping byte and the
// select register word, and forms the merged write value.
// Assumes: SEL_W < DATA_W; strobes are single-cycle.
module refsw_datapath #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] lkup_addr_in,
    input  logic              cap_lkup,
    input  logic              cap_sel,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] lkup_addr_q,
    output logic [DATA_W-1:0] merge_data
);
    logic [SEL_W-1:0]  map_byte_q;
    logic [DATA_W-1:0] sel_word_q;

    // Latch the lookup address of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)      lkup_addr_q <= '0;
        else if (accept) lkup_addr_q <= lkup_addr_in;
    end

    // Save the mapping byte and the select register word as they return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_byte_q <= '0;
            sel_word_q <= '0;
        end else begin
            if (cap_lkup) map_byte_q <= rdata[SEL_W-1:0];
            if (cap_sel)  sel_word_q <= rdata;
        end
    end

    // Replace only the select field, keep the rest of the word.
    always_comb merge_data = {sel_word_q[DATA_W-1:SEL_W], map_byte_q};

endmodule

// File: rtl/refsw_bus_master.sv
// Module: refsw_bus_master
// Drives the register port from the sequencer command and reports when
// the current access completes (wait-request low).
// Assumes: command and sources are held by the caller until ack.
module refsw_bus_master
    import refsw_pkg::*;
#(
    parameter int                ADDR_W   = 10,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 10'h141
) (
    input  bus_cmd_e          cmd,
    input  logic              use_sel_addr,
    input  logic [ADDR_W-1:0] lkup_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_wait,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              ack
);
    // Command decode onto the strobes.
    always_comb begin
        bus_rd = (cmd == CMD_RD);
        bus_wr = (cmd == CMD_WR);
    end

    // Address and write data, zero while idle.
    always_comb begin
        if (cmd == CMD_NONE)   bus_addr = '0;
        else if (use_sel_addr) bus_addr = SEL_ADDR;
        else                   bus_addr = lkup_addr;
        bus_wdata = (cmd == CMD_WR) ? wr_data : '0;
    end

    // Access completes on any cycle the target is not stalling.
    always_comb ack = (cmd != CMD_NONE) && !bus_wait;

endmodule

// File: rtl/refsw_sequencer.sv
// Module: refsw_sequencer (top)
// Switches the clock-recovery reference clock to a logical source by
// fetching its mapping byte and merging it into the select register.
// Assumes: the arbiter holds grant while request stays high.
module refsw_sequencer
    import refsw_pkg::*;
#(
    parameter int                NUM_CLK   = 5,
    parameter int                IDX_W     = 3,
    parameter int                ADDR_W    = 10,
    parameter int                DATA_W    = 32,
    parameter int                SEL_W     = 8,
    parameter logic [ADDR_W-1:0] LKUP_BASE = 10'h16A,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 10'h141
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [IDX_W-1:0]  sw_idx,
    output logic              sw_busy,
    output logic              sw_done,
    output logic              sw_err,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_wait
);
    logic              idx_ok;
    logic [ADDR_W-1:0] lkup_addr_c;
    logic [ADDR_W-1:0] lkup_addr_q;
    logic [DATA_W-1:0] merge_data;
    logic              accept;
    bus_cmd_e          cmd;
    logic              use_sel_addr;
    logic              cap_lkup;
    logic              cap_sel;
    logic              xfer_ack;

    refsw_req_check #(
        .NUM_CLK  (NUM_CLK),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W),
        .LKUP_BASE(LKUP_BASE)
    ) u_check (
        .idx      (sw_idx),
        .idx_ok   (idx_ok),
        .lkup_addr(lkup_addr_c)
    );

    refsw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (sw_req),
        .idx_ok      (idx_ok),
        .arb_gnt     (arb_gnt),
        .xfer_ack    (xfer_ack),
        .accept      (accept),
        .cmd         (cmd),
        .use_sel_addr(use_sel_addr),
        .cap_lkup    (cap_lkup),
        .cap_sel     (cap_sel),
        .arb_req     (arb_req),
        .busy        (sw_busy),
        .done        (sw_done),
        .err         (sw_err)
    );

    refsw_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SEL_W (SEL_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .lkup_addr_in(lkup_addr_c),
        .cap_lkup    (cap_lkup),
        .cap_sel     (cap_sel),
        .rdata       (bus_rdata),
        .lkup_addr_q (lkup_addr_q),
        .merge_data  (merge_data)
    );

    refsw_bus_master #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SEL_ADDR(SEL_ADDR)
    ) u_bus (
        .cmd         (cmd),
        .use_sel_addr(use_sel_addr),
        .lkup_addr   (lkup_addr_q),
        .wr_data     (merge_data),
        .bus_wait    (bus_wait),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .ack         (xfer_ack)
    );

endmodule

// File: rtl/refsw_sequencer_chk.sv
// Module: refsw_sequencer_chk
// Protocol checker bound to refsw_sequencer; observes ports only.
// Assumes: arbiter keeps grant while arb_req is high.
module refsw_sequencer_chk #(
    parameter int                ADDR_W   = 10,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 10'h141
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_busy,
    input logic              sw_done,
    input logic              sw_err,
    input logic              arb_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wait
);
    p_acc_under_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> arb_req);

    p_wr_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == SEL_ADDR));

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wait) |=> (bus_rd && $stable(bus_addr)));

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wait) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    p_req_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arb_req) |-> $past(bus_wr && !bus_wait));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done |=> !sw_done);

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done |-> (sw_busy && !arb_req));

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_busy) |-> $past(sw_done));

    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_err) |-> (!sw_busy && !arb_req));

    p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

bind refsw_sequencer refsw_sequencer_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEL_ADDR(SEL_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_busy  (sw_busy),
    .sw_done  (sw_done),
    .sw_err   (sw_err),
    .arb_req  (arb_req),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_wait (bus_wait)
);

// File: tb/refsw_sequencer_tb.sv
// Bench for refsw_sequencer: register-file and arbiter model, random and
// directed switch requests, expected values from bench functions.
module refsw_sequencer_tb;
    localparam int NCLK = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_req = 1'b0;
    logic [2:0]  sw_idx = '0;
    logic        sw_busy, sw_done, sw_err, arb_req;
    logic        arb_gnt = 1'b0;
    logic [9:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_wait = 1'b0;

    int total = 0;
    int bad   = 0;

    // Register file model.
    logic [31:0] lk_reg [NCLK];
    logic [31:0] sel_reg;
    int          wait_max = 2;

    // Access log.
    logic [9:0]  log_addr [8];
    logic        log_wr   [8];
    logic [31:0] log_data [8];
    int          log_n = 0;
    int          unstable = 0;
    int          arb_seen = 0;
    int          pre_gnt_acc = 0;

    refsw_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_idx(sw_idx),
        .sw_busy(sw_busy), .sw_done(sw_done), .sw_err(sw_err),
        .arb_req(arb_req), .arb_gnt(arb_gnt), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_rd(input logic [9:0] a);
        if (a == 10'h141) return sel_reg;
        if (a >= 10'h16A && a <= 10'h16E) return lk_reg[a - 10'h16A];
        return 32'hDEAD_BEEF;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] sel, input logic [31:0] lk);
        return {sel[31:8], lk[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bus and arbiter model, driven on falling edges.
    initial begin
        logic        p_hold = 1'b0;
        logic        p_rd = 1'b0, p_wr = 1'b0;
        logic [9:0]  p_addr = '0;
        logic [31:0] p_wd = '0;
        logic        w;
        forever begin
            @(negedge clk);
            if (p_hold && (bus_rd != p_rd || bus_wr != p_wr || bus_addr != p_addr ||
                           (p_wr && bus_wdata != p_wd)))
                unstable++;
            if (arb_req) arb_seen++;
            if ((bus_rd || bus_wr) && !arb_gnt) pre_gnt_acc++;
            if (!arb_req) arb_gnt = 1'b0;
            else if (!arb_gnt && ($urandom % 3 == 0)) arb_gnt = 1'b1;
            w = (bus_rd || bus_wr) && ($urandom % (wait_max + 1) != 0);
            bus_wait = w;
            bus_rdata = 32'h0BAD_0BAD;
            if ((bus_rd || bus_wr) && !w && log_n < 8) begin
                log_addr[log_n] = bus_addr;
                log_wr[log_n]   = bus_wr;
                if (bus_rd) begin
                    bus_rdata = model_rd(bus_addr);
                    log_data[log_n] = bus_rdata;
                end else begin
                    log_data[log_n] = bus_wdata;
                    if (bus_addr == 10'h141) sel_reg = bus_wdata;
                end
                log_n++;
            end
            p_hold = (bus_rd || bus_wr) && w;
            p_rd = bus_rd; p_wr = bus_wr; p_addr = bus_addr; p_wd = bus_wdata;
        end
    end

    task automatic load_regs(input bit directed_hi);
        for (int i = 0; i < NCLK; i++) lk_reg[i] = $urandom;
        sel_reg = directed_hi ? 32'hFFFF_FF00 : $urandom;
    endtask

    // One valid switch, optionally disturbed by a request while busy.
    task automatic run_switch(input logic [2:0] idx, input bit disturb);
        logic [31:0] sel0, lk0, expw;
        int cyc;
        sel0 = sel_reg; lk0 = lk_reg[idx];
        expw = exp_merge(sel0, lk0);
        log_n = 0; unstable = 0; pre_gnt_acc = 0;
        @(negedge clk); sw_req = 1'b1; sw_idx = idx;
        @(negedge clk); sw_req = 1'b0;
        check(sw_busy && arb_req, "R2 busy/arb_req after accept", {30'd0, sw_busy, arb_req}, 32'h3);
        check(!sw_err, "R10 err cleared on accept", {31'd0, sw_err}, 32'h0);
        cyc = 0;
        while (!sw_done && cyc < 200) begin
            if (disturb && cyc == 0) begin sw_req = 1'b1; sw_idx = (idx == 3'd0) ? 3'd4 : 3'd0; end
            else sw_req = 1'b0;
            @(negedge clk); cyc++;
        end
        sw_req = 1'b0;
        check(sw_done, "R8 done reached", {31'd0, sw_done}, 32'h1);
        check(sw_busy && !arb_req, "R7/R8 busy held, arb_req released at done", {30'd0, sw_busy, arb_req}, 32'h2);
        check(log_n == 3, "R3/R4/R5 access count", log_n, 3);
        check(log_n > 0 && log_addr[0] == 10'h16A + idx && !log_wr[0], "R3 lookup read addr", log_addr[0], 10'h16A + idx);
        check(log_n > 1 && log_addr[1] == 10'h141 && !log_wr[1], "R4 select read addr", log_addr[1], 32'h141);
        check(log_n > 2 && log_addr[2] == 10'h141 && log_wr[2], "R5 select write addr", log_addr[2], 32'h141);
        check(log_n > 2 && log_data[2] == expw, "R5 merged write data", log_data[2], expw);
        check(unstable == 0, "R6 command held during wait", unstable, 0);
        check(pre_gnt_acc == 0, "R2 no access before grant", pre_gnt_acc, 0);
        @(negedge clk);
        check(!sw_done && !sw_busy, "R8 single-cycle done, busy ends", {30'd0, sw_done, sw_busy}, 32'h0);
        if (disturb) begin
            repeat (3) @(negedge clk);
            check(!sw_busy && log_n == 3, "R9 request while busy ignored", log_n, 3);
        end
    endtask

    // A refused request.
    task automatic run_bad(input logic [2:0] idx);
        log_n = 0; arb_seen = 0;
        @(negedge clk); sw_req = 1'b1; sw_idx = idx;
        @(negedge clk); sw_req = 1'b0;
        check(sw_err && !sw_busy, "R10 err set, not busy", {30'd0, sw_err, sw_busy}, 32'h2);
        repeat (3) @(negedge clk);
        check(log_n == 0 && arb_seen == 0 && sw_err, "R10 no bus/arbiter activity, err held", log_n + arb_seen, 0);
    endtask

    initial begin
        for (int i = 0; i < NCLK; i++) lk_reg[i] = '0;
        sel_reg = '0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check({sw_busy, sw_done, sw_err, arb_req, bus_rd, bus_wr} == 6'd0, "R1 outputs in reset",
              {26'd0, sw_busy, sw_done, sw_err, arb_req, bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({sw_busy, sw_done, sw_err, arb_req, bus_rd, bus_wr} == 6'd0, "R1 outputs after reset",
              {26'd0, sw_busy, sw_done, sw_err, arb_req, bus_rd, bus_wr}, 0);

        // Directed corners: lowest and highest index, kept upper bits.
        load_regs(1'b1); run_switch(3'd0, 1'b0);
        load_regs(1'b0); run_switch(3'd4, 1'b0);
        run_bad(3'd5);
        load_regs(1'b0); run_switch(3'd2, 1'b1);
        run_bad(3'd7);
        wait_max = 6; load_regs(1'b0); run_switch(3'd3, 1'b0); wait_max = 2;

        // Random mix.
        for (int n = 0; n < 30; n++) begin
            int r;
            r = $urandom % 8;
            load_regs(1'b0);
            if (r >= NCLK) run_bad(3'(r));
            else run_switch(3'(r), ($urandom % 4) == 0);
        end

        // Mid-run reset returns to idle.
        @(negedge clk); sw_req = 1'b1; sw_idx = 3'd1;
        @(negedge clk); sw_req = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(!sw_busy && !arb_req && !sw_err, "R1 reset mid-switch", {29'd0, sw_busy, arb_req, sw_err}, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule